// File: doc/BRIEF.md
# Microwire serial EEPROM responder

This block plays the memory side of a three-wire Microwire serial link. It holds 64 words of 16 bits in internal registers. A host drives chip select, serial clock and serial data in, and the block answers on serial data out. All four pins are sampled by the block's own clock `clk`. They pass through a short synchronizer, so the host's serial clock must stay in each level for several `clk` cycles.

Each instruction is a start bit, a two-bit opcode and a six-bit word address. Reads stream words out for as long as chip select stays high. Writes take one 16-bit word and only take effect after a write-enable instruction. Lowering chip select ends any instruction at once.

The serial pins are the only stream. They carry no valid/ready handshake and no back-pressure: the host's serial clock sets the pace, and the block keeps up with every edge. All other pins are plain levels.

Top module: `mw_eeprom`

## Requirements
- R1: An instruction is accepted only when chip select rises while the serial clock is low. If chip select rises while the serial clock is high, every bit is ignored until chip select falls again.
- R2: Serial data in is sampled on rising serial-clock edges while chip select is high. Zeros are skipped until the first 1, which is the start bit, so any number of leading zeros may come before it.
- R3: After the start bit come an opcode of 2 bits and then a word address of 6 bits, both most significant bit first. Opcode 10 reads and opcode 01 writes. Opcode 00 with address bits [5:4] equal to 11 enables writes. Opcode 00 with address bits [5:4] equal to 00 disables writes. Every other code changes nothing, and the output stays 0 for the rest of that instruction.
- R4: On a read, the rising edge that samples the last address bit drives a dummy 0 on serial data out. Each later rising edge drives the next data bit, most significant bit first. The output changes only on rising edges.
- R5: While chip select stays high after the last bit of a read word, the word address advances by one, wrapping from 63 to 0. The next word follows at once, with no dummy bit.
- R6: With writes enabled, a write instruction followed by 16 data bits, most significant first, stores the word at the addressed location once the 16th bit is sampled.
- R7: With writes disabled, a write instruction leaves the memory unchanged.
- R8: Chip select low aborts the current instruction and drives serial data out to 0. A write that has not received all 16 data bits stores nothing.
- R9: After reset, serial data out is 0, writes are disabled and every word holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |

## Verification
A change on a serial pin reaches the decoder after the synchronizer stages plus one edge-detect register. With the default two synchronizer stages, the output bit for a serial-clock rise, and the forced zero after chip select falls, both appear on the third `clk` rising edge after the pin changes. The bench drives pins on falling `clk` edges. Its reference model updates the expected output just after that third rising edge, and it compares on every falling edge while a test runs, so a bit that arrives early or late is caught in the cycle it goes wrong. Each serial-clock half period lasts eight `clk` cycles, so every expected bit is held long enough to be compared several times. Whole words shifted out are also compared against the model's memory.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int OPC_W = 2;

  localparam logic [OPC_W-1:0] OPC_CTRL  = 2'b00;
  localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;
  localparam logic [OPC_W-1:0] OPC_READ  = 2'b10;

  localparam logic [1:0] CTRL_WEN  = 2'b11;
  localparam logic [1:0] CTRL_WDIS = 2'b00;

  typedef enum logic [2:0] {
    S_OFF,
    S_HUNT,
    S_BLOCK,
    S_CMD,
    S_RD,
    S_WR,
    S_DONE
  } mw_state_t;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_lvl,
  output logic sk_lvl,
  output logic di_lvl,
  output logic cs_rise,
  output logic sk_rise
);
  localparam int PINS = 3;

  logic [PINS-1:0] pins_s;
  logic            cs_prev, sk_prev;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign pins_s = {cs_i, sk_i, di_i};
    end else begin : g_chain
      logic [PINS-1:0] stage [SYNC_STAGES];
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_st
        always_ff @(posedge clk) begin
          if (!rst_n) stage[i] <= '0;
          else if (i == 0) stage[i] <= {cs_i, sk_i, di_i};
          else stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
      end
      assign pins_s = stage[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_prev <= 1'b0;
      sk_prev <= 1'b0;
    end else begin
      cs_prev <= pins_s[2];
      sk_prev <= pins_s[1];
    end
  end

  assign cs_lvl  = pins_s[2];
  assign sk_lvl  = pins_s[1];
  assign di_lvl  = pins_s[0];
  assign cs_rise = pins_s[2] & ~cs_prev;
  assign sk_rise = pins_s[1] & ~sk_prev;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) words[w] <= '0;
        else if (we && addr == ADDR_W'(w)) words[w] <= wdata;
      end
    end
  endgenerate

  assign rdata = words[addr];
endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              sk_lvl,
  input  logic              di_lvl,
  input  logic              cs_rise,
  input  logic              sk_rise,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wen,
  output logic              dout
);
  localparam int CMD_BITS = OPC_W + ADDR_W;
  localparam int CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);

  mw_state_t             state;
  logic [CNT_W-1:0]      cnt;
  logic [CMD_BITS-2:0]   cmd;
  logic [CMD_BITS-1:0]   cmd_next;
  logic [OPC_W-1:0]      opc;
  logic [ADDR_W-1:0]     cmd_addr;
  logic [ADDR_W-1:0]     addr;
  logic [DATA_W-1:0]     wbuf;

  assign cmd_next  = {cmd, di_lvl};
  assign opc       = cmd_next[CMD_BITS-1 -: OPC_W];
  assign cmd_addr  = cmd_next[ADDR_W-1:0];
  assign mem_addr  = addr;
  assign mem_wdata = wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_OFF;
      cnt    <= '0;
      cmd    <= '0;
      addr   <= '0;
      wbuf   <= '0;
      wen    <= 1'b0;
      dout   <= 1'b0;
      mem_we <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (!cs_lvl) begin
        state <= S_OFF;
        dout  <= 1'b0;
      end else if (cs_rise) begin
        state <= sk_lvl ? S_BLOCK : S_HUNT;
        dout  <= 1'b0;
      end else if (sk_rise) begin
        unique case (state)
          S_HUNT: begin
            if (di_lvl) begin
              state <= S_CMD;
              cnt   <= '0;
            end
          end
          S_CMD: begin
            cmd <= cmd_next[CMD_BITS-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CMD) begin
              cnt <= '0;
              unique case (opc)
                OPC_READ: begin
                  addr  <= cmd_addr;
                  dout  <= 1'b0;
                  state <= S_RD;
                end
                OPC_WRITE: begin
                  addr  <= cmd_addr;
                  state <= S_WR;
                end
                OPC_CTRL: begin
                  if (cmd_addr[ADDR_W-1 -: 2] == CTRL_WEN)  wen <= 1'b1;
                  if (cmd_addr[ADDR_W-1 -: 2] == CTRL_WDIS) wen <= 1'b0;
                  state <= S_DONE;
                end
                default: state <= S_DONE;
              endcase
            end
          end
          S_RD: begin
            dout <= mem_rdata[LAST_DATA - cnt];
            if (cnt == LAST_DATA) begin
              cnt  <= '0;
              addr <= addr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WR: begin
            wbuf <= {wbuf[DATA_W-2:0], di_lvl};
            if (cnt == LAST_DATA) begin
              mem_we <= wen;
              state  <= S_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: without a serial-clock rise or chip-select change the state holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && !cs_rise && !sk_rise) |=> $stable(state));

  // R1: a blocked instruction leaves only when chip select drops
  a_r1_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLOCK) |=> (state == S_BLOCK || state == S_OFF));

  // R4: the first bit after entering a read is the dummy zero
  a_r4_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_RD) |-> !dout);

  // R5: word boundary during a read advances the address with wrap
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && cs_lvl && !cs_rise && sk_rise && cnt == LAST_DATA)
      |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  logic              cs_lvl, sk_lvl, di_lvl, cs_rise, sk_rise;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we, wen;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  mw_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_i),
    .sk_i    (sk_i),
    .di_i    (di_i),
    .cs_lvl  (cs_lvl),
    .sk_lvl  (sk_lvl),
    .di_lvl  (di_lvl),
    .cs_rise (cs_rise),
    .sk_rise (sk_rise)
  );

  mw_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (cs_lvl),
    .sk_lvl    (sk_lvl),
    .di_lvl    (di_lvl),
    .cs_rise   (cs_rise),
    .sk_rise   (sk_rise),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .wen       (wen),
    .dout      (do_o)
  );

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  // R7: the array is written only while writes are enabled
  a_r7_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen);

  // R8: chip select low forces the output to zero on the next edge
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |=> !do_o);
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o;

  int   tests = 0, fails = 0, prints = 0;
  bit   chk_en = 1'b0;
  logic exp_do = 1'b0;
  logic [15:0] mem_m [64];
  bit   wen_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom uut (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_i  (cs),
    .sk_i  (sk),
    .di_i  (di),
    .do_o  (do_o)
  );

  // per-clock comparison of serial data out against the model (R4, R5, R8)
  always @(negedge clk) begin
    if (chk_en) begin
      tests++;
      if (do_o !== exp_do) begin
        fails++;
        if (prints < 20) begin
          prints++;
          $display("FAIL R4 serial out at %0t: got %b expected %b", $time, do_o, exp_do);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic clk_bit(input logic b, input logic nexp, output logic got);
    @(negedge clk);
    di = b;
    repeat (HALF) @(negedge clk);
    sk = 1'b1;
    repeat (LAT) @(posedge clk);
    #1 exp_do = nexp;
    repeat (HALF - LAT) @(negedge clk);
    got = do_o;
    sk = 1'b0;
  endtask

  task automatic cs_up();
    @(negedge clk);
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk);
    cs = 1'b0;
    repeat (LAT) @(posedge clk);
    #1 exp_do = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input int pad, input logic [1:0] opc, input logic [5:0] a);
    logic g;
    for (int i = 0; i < pad; i++) clk_bit(1'b0, 1'b0, g);
    clk_bit(1'b1, 1'b0, g);
    for (int i = 1; i >= 0; i--) clk_bit(opc[i], 1'b0, g);
    for (int i = 5; i >= 0; i--) clk_bit(a[i], 1'b0, g);
  endtask

  // read nbits after the command; blocked: expect silence (R1)
  task automatic do_read(input logic [5:0] a, input int nbits, input bit blocked,
                         input string req);
    logic g;
    logic [15:0] word;
    logic [15:0] expw;
    if (!blocked) cs_up();
    send_cmd(2, 2'b10, a);
    word = '0;
    for (int n = 0; n < nbits; n++) begin
      expw = blocked ? 16'h0 : mem_m[6'(a + 6'(n / 16))];
      clk_bit(1'b0, expw[15 - (n % 16)], g);
      word = {word[14:0], g};
      if (n % 16 == 15) check(word == expw, req, word, expw);
    end
    cs_down();
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input int nbits,
                          input int pad);
    logic g;
    cs_up();
    send_cmd(pad, 2'b01, a);
    for (int i = 0; i < nbits; i++) clk_bit(d[15 - i], 1'b0, g);
    cs_down();
    if (nbits == 16 && wen_m) mem_m[a] = d;
  endtask

  task automatic do_ctrl(input logic [1:0] opc, input logic [5:0] a);
    cs_up();
    send_cmd(0, opc, a);
    cs_down();
    if (opc == 2'b00 && a[5:4] == 2'b11) wen_m = 1'b1;
    if (opc == 2'b00 && a[5:4] == 2'b00) wen_m = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic g;
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(do_o == 1'b0, "R9 do after reset", do_o, 0);
    chk_en = 1'b1;

    // R9: memory cleared by reset
    do_read(6'd5, 16, 1'b0, "R9 reset word");
    // R7: write with writes disabled (reset state)
    do_write(6'd3, 16'hBEEF, 16, 0);
    do_read(6'd3, 16, 1'b0, "R7 disabled write");
    // R3 enable, R2 leading zeros, R6 writes
    do_ctrl(2'b00, 6'b110000);
    do_write(6'd3, 16'hBEEF, 16, 3);
    do_write(6'd4, 16'h1234, 16, 0);
    do_write(6'd63, 16'hA5C3, 16, 7);
    do_write(6'd0, 16'h0F0F, 16, 1);
    do_read(6'd3, 32, 1'b0, "R6 R5 stream");
    do_read(6'd63, 32, 1'b0, "R5 wrap");
    // R8: truncated write, aborted read
    do_write(6'd10, 16'hFFFF, 10, 0);
    do_read(6'd10, 16, 1'b0, "R8 partial write");
    do_read(6'd4, 5, 1'b0, "R8 abort");
    // R1: chip select rising while serial clock is high
    @(negedge clk); sk = 1'b1;
    repeat (HALF) @(negedge clk);
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
    sk = 1'b0;
    repeat (HALF) @(negedge clk);
    do_read(6'd3, 16, 1'b1, "R1 blocked");
    // R3: unused opcode 11 changes nothing, output quiet
    cs_up();
    send_cmd(0, 2'b11, 6'd3);
    for (int i = 0; i < 16; i++) clk_bit(1'b1, 1'b0, g);
    cs_down();
    do_read(6'd3, 16, 1'b0, "R3 unused opcode");
    // R3 disable then R7 write refused
    do_ctrl(2'b00, 6'b000000);
    do_write(6'd4, 16'hFFFF, 16, 0);
    do_read(6'd4, 16, 1'b0, "R3 R7 after disable");

    chk_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule